// File: doc/BRIEF.md
# DMA Channel Status and Remaining-Byte Counter

This block holds the status and remaining-byte count of one DMA channel in a single 32-bit word. Software reads that word and writes it through byte lanes. The top byte carries the status flags and the low 24 bits carry the number of bytes still to move. Software loads the count while the channel is idle. The transfer engine then pulses a start strobe. The block checks that the count suits the chosen access width. If it does, the block marks the channel busy.

Each completed write beat from the engine lowers the count by the access width in bytes. When the count reaches zero, busy drops and done rises on the same edge. A bus error from the engine on the source side or the destination side also ends the transfer, records which side failed and raises done. Writing one to the done bit acknowledges the channel. That write clears done, the error flags, busy and the count.

The engine is modelled as plain strobes. Address generation, bus mastering and request arbitration sit outside this block.

Top module: `dma_chan_stat`

## Requirements
- R1: After a synchronous reset, every bit of `rd_data` is 0.
- R2: `rd_data` is laid out as follows: bit 30 is the configuration-error flag, bit 29 the source-side bus error, bit 28 the destination-side bus error, bit 26 the request-pending flag, bit 25 busy, bit 24 done, and bits 23:0 the remaining count. Bits 31 and 27 always read 0.
- R3: A write with byte enables `wr_be[0]`, `wr_be[1]` or `wr_be[2]` loads count bits 7:0, 15:8 or 23:16 respectively from `wr_data`, but only when the channel is idle. A count write is dropped while busy. It is also dropped on a cycle in which `start` is high while idle.
- R4: While busy, each `beat` lowers the count by 1, 2 or 4 for size codes 0 (8-bit), 1 (16-bit) and 2 (32-bit). The size code is captured at start. A `beat` while idle has no effect, and the count never wraps below zero.
- R5: The beat that brings the count to zero clears busy and sets done on the same clock edge.
- R6: A start while idle sets the configuration-error flag and leaves busy and the count unchanged in three cases: size code 2 with count bits 1:0 not 00, size code 1 with count bit 0 set, or size code 3.
- R7: An aligned start while idle with a nonzero count sets busy on the next edge. An aligned start with a zero count sets done without setting busy.
- R8: While busy, `err_src` sets bit 29 and `err_dst` sets bit 28. Either one clears busy, sets done and freezes the count. Error strobes while idle are ignored.
- R9: A write with `wr_be[3]` set and `wr_data[24]`=1 clears done, the configuration-error flag, both bus-error flags, busy and the count. This takes priority over every other event in the same cycle.
- R10: Writing ones to status bits 31:25 through `wr_be[3]`, with `wr_data[24]`=0, changes nothing.
- R11: The request-pending flag shows the value `req_in` had at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_be | input | 4 | Byte enables; lane 3 is the status byte |
| wr_data | input | 32 | Software write data |
| start | input | 1 | Engine start strobe |
| xfer_size | input | 2 | Access width code: 0 byte, 1 half, 2 word, 3 reserved |
| beat | input | 1 | Engine completed one write beat |
| err_src | input | 1 | Source-side bus error strobe |
| err_dst | input | 1 | Destination-side bus error strobe |
| req_in | input | 1 | Request-pending level from the engine |
| rd_data | output | 32 | Status and count word |

## Verification
The bench builds the block with its default 24-bit count. At that width each of the three count byte lanes is wired to its own field bits, so it can be loaded on its own into a value such as 0xAB0012. With that width, decrements and saturation are checked against the full field, and a 24-bit count that fits the 16-bit alignment rule is exercised. The run also covers the same-cycle collisions that set the priority rules: a start during a count write, and an acknowledge on the same cycle as both a beat and a bus error.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int WORD_W   = 32;
    localparam int BIT_CE   = 30;
    localparam int BIT_BES  = 29;
    localparam int BIT_BED  = 28;
    localparam int BIT_REQ  = 26;
    localparam int BIT_BUSY = 25;
    localparam int BIT_DONE = 24;
    localparam int STAT_LANE = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic ce;
        logic bes;
        logic bed;
        logic req;
        logic busy;
        logic done;
    } stat_t;

    function automatic logic [2:0] step_of(input xfer_size_e s);
        case (s)
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic size_fits(input xfer_size_e s, input logic [1:0] low);
        case (s)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return ~low[0];
            SZ_WORD: return (low == 2'b00);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dcs_count.sv
module dcs_count
    import dcs_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load_en,
    input  logic [CNT_W/8-1:0] lane_en,
    input  logic [CNT_W-1:0] load_data,
    input  logic             dec_en,
    input  logic [2:0]       step,
    output logic [CNT_W-1:0] cnt,
    output logic             last_beat
);
    localparam int LANES = CNT_W / 8;

    logic [CNT_W-1:0] merged;
    logic [CNT_W-1:0] step_ext;
    logic             at_end;
    logic [CNT_W-1:0] dec_val;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = lane_en[g] ? load_data[g*8 +: 8] : cnt[g*8 +: 8];
    end

    assign step_ext  = CNT_W'(step);
    assign at_end    = (cnt <= step_ext);
    assign dec_val   = at_end ? '0 : (cnt - step_ext);
    assign last_beat = dec_en && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (dec_en) begin
            cnt <= dec_val;
        end else if (load_en) begin
            cnt <= merged;
        end
    end

endmodule

// File: rtl/dcs_start_chk.sv
module dcs_start_chk
    import dcs_pkg::*;
(
    input  logic       start,
    input  logic       busy,
    input  xfer_size_e size,
    input  logic [1:0] cnt_low,
    input  logic       cnt_zero,
    output logic       go,
    output logic       empty_done,
    output logic       cfg_err
);
    logic attempt;
    logic fits;

    assign attempt    = start && !busy;
    assign fits       = size_fits(size, cnt_low);
    assign cfg_err    = attempt && !fits;
    assign go         = attempt && fits && !cnt_zero;
    assign empty_done = attempt && fits && cnt_zero;

endmodule

// File: rtl/dcs_flags.sv
module dcs_flags
    import dcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  go,
    input  logic  empty_done,
    input  logic  cfg_err,
    input  logic  last_beat,
    input  logic  src_ev,
    input  logic  dst_ev,
    input  logic  req_in,
    output stat_t stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat.req <= req_in;
            if (clr) begin
                stat.ce   <= 1'b0;
                stat.bes  <= 1'b0;
                stat.bed  <= 1'b0;
                stat.busy <= 1'b0;
                stat.done <= 1'b0;
            end else begin
                if (cfg_err)    stat.ce   <= 1'b1;
                if (go)         stat.busy <= 1'b1;
                if (empty_done) stat.done <= 1'b1;
                if (src_ev)     stat.bes  <= 1'b1;
                if (dst_ev)     stat.bed  <= 1'b1;
                if (src_ev || dst_ev || last_beat) begin
                    stat.busy <= 1'b0;
                    stat.done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dma_chan_stat.sv
module dma_chan_stat
    import dcs_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    input  logic        start,
    input  logic [1:0]  xfer_size,
    input  logic        beat,
    input  logic        err_src,
    input  logic        err_dst,
    input  logic        req_in,
    output logic [31:0] rd_data
);
    localparam int LANES = CNT_W / 8;

    stat_t            stat_q;
    xfer_size_e       size_q;
    xfer_size_e       size_in;
    logic [CNT_W-1:0] cnt_q;
    logic             clr;
    logic             busy_w;
    logic             any_err;
    logic             src_ev;
    logic             dst_ev;
    logic             dec_en;
    logic             load_en;
    logic             last_beat;
    logic             go;
    logic             empty_done;
    logic             cfg_err;
    logic [2:0]       cur_step;

    assign size_in  = xfer_size_e'(xfer_size);
    assign busy_w   = stat_q.busy;
    assign clr      = wr_en && wr_be[STAT_LANE] && wr_data[BIT_DONE];
    assign any_err  = err_src || err_dst;
    assign src_ev   = busy_w && !clr && err_src;
    assign dst_ev   = busy_w && !clr && err_dst;
    assign dec_en   = busy_w && !clr && beat && !any_err;
    assign load_en  = wr_en && (|wr_be[LANES-1:0]) && !busy_w && !start;
    assign cur_step = step_of(size_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= SZ_BYTE;
        end else if (go) begin
            size_q <= size_in;
        end
    end

    dcs_start_chk u_start (
        .start      (start && !clr),
        .busy       (busy_w),
        .size       (size_in),
        .cnt_low    (cnt_q[1:0]),
        .cnt_zero   (cnt_q == '0),
        .go         (go),
        .empty_done (empty_done),
        .cfg_err    (cfg_err)
    );

    dcs_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .load_en   (load_en),
        .lane_en   (wr_be[LANES-1:0]),
        .load_data (wr_data[CNT_W-1:0]),
        .dec_en    (dec_en),
        .step      (cur_step),
        .cnt       (cnt_q),
        .last_beat (last_beat)
    );

    dcs_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .go         (go),
        .empty_done (empty_done),
        .cfg_err    (cfg_err),
        .last_beat  (last_beat),
        .src_ev     (src_ev),
        .dst_ev     (dst_ev),
        .req_in     (req_in),
        .stat       (stat_q)
    );

    always_comb begin
        rd_data              = '0;
        rd_data[CNT_W-1:0]   = cnt_q;
        rd_data[BIT_CE]      = stat_q.ce;
        rd_data[BIT_BES]     = stat_q.bes;
        rd_data[BIT_BED]     = stat_q.bed;
        rd_data[BIT_REQ]     = stat_q.req;
        rd_data[BIT_BUSY]    = stat_q.busy;
        rd_data[BIT_DONE]    = stat_q.done;
    end

endmodule

// File: rtl/dcs_sva.sv
module dcs_sva #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic [31:0]      rd_data,
    input logic             clr,
    input logic             beat,
    input logic             err_src,
    input logic             err_dst,
    input logic             start,
    input logic [1:0]       xfer_size,
    input logic             req_in,
    input logic [2:0]       cur_step
);
    logic [CNT_W-1:0] cnt;
    logic busy, done, ce, bes, req, misfit;

    assign cnt  = rd_data[CNT_W-1:0];
    assign busy = rd_data[25];
    assign done = rd_data[24];
    assign ce   = rd_data[30];
    assign bes  = rd_data[29];
    assign req  = rd_data[26];
    assign misfit = (xfer_size == 2'd3) ||
                    (xfer_size == 2'd2 && cnt[1:0] != 2'b00) ||
                    (xfer_size == 2'd1 && cnt[0]);

    // R2
    assert_fixed_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_data[31] && !rd_data[27]);

    // R4
    assert_dec_by_step_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && beat && !clr && !err_src && !err_dst && cnt > CNT_W'(cur_step))
        |=> (cnt == $past(cnt) - CNT_W'($past(cur_step))));

    // R3
    assert_cnt_hold_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat && !clr) |=> $stable(cnt));

    // R5
    assert_end_sets_done_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr) |=> (busy || done));

    // R6
    assert_misfit_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !clr && misfit) |=> (ce && !busy));

    // R8
    assert_src_err_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && err_src && !clr) |=> (bes && !busy && done));

    // R9
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && !done && !busy && !ce));

    // R11
    assert_req_mirror_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (req == $past(req_in)));

endmodule

bind dma_chan_stat dcs_sva #(.CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .rd_data   (rd_data),
    .clr       (clr),
    .beat      (beat),
    .err_src   (err_src),
    .err_dst   (err_dst),
    .start     (start),
    .xfer_size (xfer_size),
    .req_in    (req_in),
    .cur_step  (cur_step)
);

// File: tb/tb_dma_chan_stat.sv
module tb_dma_chan_stat;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic [1:0]  xfer_size = '0;
    logic        beat = 1'b0;
    logic        err_src = 1'b0;
    logic        err_dst = 1'b0;
    logic        req_in = 1'b0;
    logic [31:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    dma_chan_stat dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .start(start), .xfer_size(xfer_size), .beat(beat), .err_src(err_src),
        .err_dst(err_dst), .req_in(req_in), .rd_data(rd_data)
    );

    function automatic logic [31:0] mk(input logic ce, input logic bes, input logic bed,
                                       input logic rq, input logic bsy, input logic dn,
                                       input logic [23:0] c);
        return {1'b0, ce, bes, bed, 1'b0, rq, bsy, dn, c};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected word after each edge
    always @(posedge clk) begin
        #2;
        if (q_exp.size() > 0) check(rd_data, q_exp.pop_front(), q_tag.pop_front());
    end

    // driver: applies one cycle of stimulus and queues the word expected after the edge
    task automatic step(input logic we, input logic [3:0] be, input logic [31:0] wd,
                        input logic st, input logic [1:0] sz, input logic bt,
                        input logic es, input logic ed, input logic rq,
                        input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = we; wr_be = be; wr_data = wd; start = st; xfer_size = sz;
        beat = bt; err_src = es; err_dst = ed; req_in = rq;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic wcnt(input logic [3:0] be, input logic [31:0] wd, input logic [31:0] exp, input string tag);
        step(1, be, wd, 0, 0, 0, 0, 0, 0, exp, tag);
    endtask

    task automatic ack(input string tag);
        step(1, 4'b1000, 32'h0100_0000, 0, 0, 0, 0, 0, 0, 32'h0, tag);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(rd_data, 32'h0, "R1 reset");

        wcnt(4'b0111, 32'h0000_0010, mk(0,0,0,0,0,0,24'h10), "R3 idle load");
        step(0,0,0, 1,2'd2, 0,0,0,0, mk(0,0,0,0,1,0,24'h10), "R7 aligned start");
        wcnt(4'b0111, 32'h00FF_FFFF, mk(0,0,0,0,1,0,24'h10), "R3 write while busy");
        step(0,0,0, 0,0, 1,0,0,0, mk(0,0,0,0,1,0,24'h0C), "R4 word beat");
        step(0,0,0, 0,0, 1,0,0,1, mk(0,0,0,1,1,0,24'h08), "R11 req high");
        step(0,0,0, 0,0, 1,0,0,0, mk(0,0,0,0,1,0,24'h04), "R11 req low");
        step(0,0,0, 0,0, 1,0,0,0, mk(0,0,0,0,0,1,24'h00), "R5 last beat");
        step(0,0,0, 0,0, 1,0,0,0, mk(0,0,0,0,0,1,24'h00), "R4 idle beat no wrap");
        step(1,4'b1000,32'hFE00_0000, 0,0, 0,0,0,0, mk(0,0,0,0,0,1,24'h00), "R10 status write ignored");
        ack("R9 ack");

        wcnt(4'b0001, 32'h3, mk(0,0,0,0,0,0,24'h3), "R3 load 3");
        step(0,0,0, 1,2'd2, 0,0,0,0, mk(1,0,0,0,0,0,24'h3), "R6 word misfit");
        ack("R9 ack ce");
        wcnt(4'b0001, 32'h3, mk(0,0,0,0,0,0,24'h3), "R3 load 3");
        step(0,0,0, 1,2'd3, 0,0,0,0, mk(1,0,0,0,0,0,24'h3), "R6 reserved size");
        ack("R9 ack ce");
        wcnt(4'b0001, 32'h3, mk(0,0,0,0,0,0,24'h3), "R3 load 3");
        step(0,0,0, 1,2'd1, 0,0,0,0, mk(1,0,0,0,0,0,24'h3), "R6 half misfit");
        ack("R9 ack ce");

        wcnt(4'b0111, 32'h5, mk(0,0,0,0,0,0,24'h5), "R3 load 5");
        step(0,0,0, 1,2'd0, 0,0,0,0, mk(0,0,0,0,1,0,24'h5), "R7 byte start");
        step(0,0,0, 0,0, 1,0,0,0, mk(0,0,0,0,1,0,24'h4), "R4 byte beat");
        step(0,0,0, 0,0, 0,1,0,0, mk(0,1,0,0,0,1,24'h4), "R8 src error");
        step(0,0,0, 0,0, 0,0,1,0, mk(0,1,0,0,0,1,24'h4), "R8 idle error ignored");
        ack("R9 ack errors");

        wcnt(4'b0111, 32'h6, mk(0,0,0,0,0,0,24'h6), "R3 load 6");
        step(0,0,0, 1,2'd1, 0,0,0,0, mk(0,0,0,0,1,0,24'h6), "R7 half start");
        step(0,0,0, 0,0, 1,0,0,0, mk(0,0,0,0,1,0,24'h4), "R4 half beat");
        step(1,4'b1000,32'h0100_0000, 0,0, 1,0,1,0, 32'h0, "R9 ack priority");
        step(0,0,0, 1,2'd2, 0,0,0,0, mk(0,0,0,0,0,1,24'h0), "R7 zero count start");
        ack("R9 ack");

        wcnt(4'b0100, 32'h00AB_0000, mk(0,0,0,0,0,0,24'hAB0000), "R3 lane 2");
        wcnt(4'b0001, 32'h0000_0012, mk(0,0,0,0,0,0,24'hAB0012), "R3 lane 0");
        step(1,4'b0111,32'h0000_00FF, 1,2'd1, 0,0,0,0, mk(0,0,0,0,1,0,24'hAB0012), "R3 write dropped at start");
        step(0,0,0, 0,0, 1,0,0,0, mk(0,0,0,0,1,0,24'hAB0010), "R4 wide half beat");
        step(0,0,0, 0,0, 0,0,1,0, mk(0,0,1,0,0,1,24'hAB0010), "R8 dst error");
        ack("R9 ack");
        step(0,0,0, 0,0, 0,0,0,0, 32'h0, "R2 idle word");

        @(negedge clk);
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule